// File: doc/BRIEF.md
# Eight-Bit Compare-Match Timer

An 8-bit up-counter with two programmable time constants and a flag/output control register, reached over a small synchronous register bus. The count rate comes from a free-running internal divider (divide by 8, 64 or 1024) or from an external clock pin. The pin is synchronised and can be counted on its rising edges, its falling edges or both. The clock select can also stop the counter.

When the counter advances onto a time constant, a sticky match flag for that constant is raised. A wrap from 0xFF to 0x00 raises a sticky overflow flag. The flags are set only by hardware. Software clears a flag by reading the status register while the flag is 1 and then writing 0 to that bit. Each match event can also drive the timer output pin low, drive it high or toggle it, as four output-select bits in the status register choose.

Top module: `cmt_timer`

## Requirements
- R1: After reset, reads return: control (address 0) 0x00, status (address 1) 0x10, counter (address 2) 0x00, constant A (address 3) 0xFF, constant B (address 4) 0xFF. tmo_o is 0.
- R2: Clock select values 000 and 100 (control bits 2:0) hold the counter. External edges and the internal divider have no effect on it.
- R3: Clock select 001, 010 and 011 advance the counter exactly once per 8, 64 and 1024 clk_i cycles.
- R4: Clock select 101 counts each rising edge of ext_clk_i once. 110 counts each falling edge once. 111 counts every edge.
- R5: Status bit 6 (flag A) sets when the counter advances to constant A. Status bit 7 (flag B) sets when it advances to constant B.
- R6: Status bit 5 (overflow) sets when the counter advances from 0xFF to 0x00, and not on any other step.
- R7: Status bit 4 always reads 1. Writing 1 to status bits 7:5 never sets a flag.
- R8: A write of 0 to a flag bit clears that flag only if a status read (rd_i) since the last status write saw the flag at 1. Any status write ends that permission.
- R9: A hardware set in the same cycle as a permitted clear leaves the flag at 1.
- R10: Status bits 1:0 act on a match A and bits 3:2 act on a match B, with the codes 00 keep, 01 low, 10 high, 11 toggle applied to tmo_o. When both matches occur together, only the B code applies.
- R11: Control bits 2:0, the counter and both constants are read/write. Control bits 7:3 read 0. A counter write takes precedence over a count in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address (0 control, 1 status, 2 counter, 3 constant A, 4 constant B) |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe, needed to permit flag clearing |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| ext_clk_i | input | 1 | External count clock, asynchronous |
| tmo_o | output | 1 | Timer output pin |

## Verification
A register write takes effect on the clk_i rising edge that ends the write. The bench drives on falling edges and reads back on the next falling edge. An ext_clk_i edge moves the counter on the third rising edge of clk_i after it. Flags and tmo_o update on that same edge, so each external pulse is held high and low for four cycles, and all results are sampled after the pulse ends. The set-wins case places a status write exactly on that third edge. Divider rates are checked by reading the counter two times exactly 4×N cycles apart, which gives exactly four counts whatever the divider phase.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL = 3'd0,
    ADDR_STAT = 3'd1,
    ADDR_CNT  = 3'd2,
    ADDR_TCA  = 3'd3,
    ADDR_TCB  = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    PIN_KEEP   = 2'b00,
    PIN_LOW    = 2'b01,
    PIN_HIGH   = 2'b10,
    PIN_TOGGLE = 2'b11
  } pin_act_e;

  localparam logic [DATA_W-1:0] TC_RST = '1;
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int unsigned PRE_W  = 10,
  parameter int unsigned TAP_LO = 2,
  parameter int unsigned TAP_MD = 5,
  parameter int unsigned TAP_HI = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic [2:0] tick_o
);
  localparam int unsigned TAPS [3] = '{TAP_LO, TAP_MD, TAP_HI};

  logic [PRE_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  // all low bits up to the tap at 1: the tap falls on the next edge
  for (genvar g = 0; g < 3; g++) begin : g_tap
    logic tick_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tick_q <= 1'b0;
      else         tick_q <= &div_q[TAPS[g]:0];
    end
    assign tick_o[g] = tick_q;
  end
endmodule

// File: rtl/cmt_edge_sync.sv
module cmt_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/cmt_pin_ctl.sv
module cmt_pin_ctl
  import cmt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       match_a_i,
  input  logic       match_b_i,
  input  logic [1:0] sel_a_i,
  input  logic [1:0] sel_b_i,
  output logic       pin_o
);
  pin_act_e act;
  logic     pin_q;

  always_comb begin
    if (match_b_i)      act = pin_act_e'(sel_b_i);
    else if (match_a_i) act = pin_act_e'(sel_a_i);
    else                act = PIN_KEEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else begin
      unique case (act)
        PIN_LOW:    pin_q <= 1'b0;
        PIN_HIGH:   pin_q <= 1'b1;
        PIN_TOGGLE: pin_q <= ~pin_q;
        default:    pin_q <= pin_q;
      endcase
    end
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
  import cmt_pkg::*;
#(
  parameter int unsigned PRE_W  = 10,
  parameter int unsigned TAP_LO = 2,
  parameter int unsigned TAP_MD = 5,
  parameter int unsigned TAP_HI = PRE_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ext_clk_i,
  output logic              tmo_o
);
  localparam int unsigned FB = 7, FA = 6, FO = 5;

  logic [2:0]        clk_sel_q;
  logic [DATA_W-1:0] cnt_q, tca_q, tcb_q, cnt_inc;
  logic [3:0]        os_q;
  logic              flag_a_q, flag_b_q, flag_o_q;
  logic [2:0]        arm_q;
  logic [2:0]        pre_tick;
  logic              ext_rise, ext_fall, tick;
  logic              wr_ctrl, wr_stat, wr_cnt, wr_tca, wr_tcb, rd_stat;
  logic              step, set_a, set_b, set_o;
  logic              clr_a, clr_b, clr_o;

  cmt_prescaler #(
    .PRE_W (PRE_W), .TAP_LO(TAP_LO), .TAP_MD(TAP_MD), .TAP_HI(TAP_HI)
  ) i_pre (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_o(pre_tick)
  );

  cmt_edge_sync #(.STAGES(2)) i_sync (
    .clk_i  (clk_i), .rst_ni(rst_ni), .async_i(ext_clk_i),
    .rise_o (ext_rise), .fall_o(ext_fall)
  );

  always_comb begin
    unique case (clk_sel_q)
      3'b001:  tick = pre_tick[0];
      3'b010:  tick = pre_tick[1];
      3'b011:  tick = pre_tick[2];
      3'b101:  tick = ext_rise;
      3'b110:  tick = ext_fall;
      3'b111:  tick = ext_rise | ext_fall;
      default: tick = 1'b0;
    endcase
  end

  assign wr_ctrl = wr_i && (addr_i == ADDR_CTRL);
  assign wr_stat = wr_i && (addr_i == ADDR_STAT);
  assign wr_cnt  = wr_i && (addr_i == ADDR_CNT);
  assign wr_tca  = wr_i && (addr_i == ADDR_TCA);
  assign wr_tcb  = wr_i && (addr_i == ADDR_TCB);
  assign rd_stat = rd_i && (addr_i == ADDR_STAT);

  // a software counter write overrides the count step
  assign cnt_inc = cnt_q + 1'b1;
  assign step    = tick && !wr_cnt;
  assign set_a   = step && (cnt_inc == tca_q);
  assign set_b   = step && (cnt_inc == tcb_q);
  assign set_o   = step && (&cnt_q);

  assign clr_a = wr_stat && arm_q[1] && !wdata_i[FA];
  assign clr_b = wr_stat && arm_q[2] && !wdata_i[FB];
  assign clr_o = wr_stat && arm_q[0] && !wdata_i[FO];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sel_q <= '0;
      cnt_q     <= '0;
      tca_q     <= TC_RST;
      tcb_q     <= TC_RST;
      os_q      <= '0;
    end else begin
      if (wr_ctrl) clk_sel_q <= wdata_i[2:0];
      if (wr_tca)  tca_q     <= wdata_i;
      if (wr_tcb)  tcb_q     <= wdata_i;
      if (wr_stat) os_q      <= wdata_i[3:0];
      if (wr_cnt)    cnt_q <= wdata_i;
      else if (tick) cnt_q <= cnt_inc;
    end
  end

  // set beats clear; a clear needs a prior read that saw the flag high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_a_q <= 1'b0;
      flag_b_q <= 1'b0;
      flag_o_q <= 1'b0;
      arm_q    <= '0;
    end else begin
      flag_a_q <= set_a | (flag_a_q & ~clr_a);
      flag_b_q <= set_b | (flag_b_q & ~clr_b);
      flag_o_q <= set_o | (flag_o_q & ~clr_o);
      if (wr_stat)      arm_q <= '0;
      else if (rd_stat) arm_q <= arm_q | {flag_b_q, flag_a_q, flag_o_q};
    end
  end

  cmt_pin_ctl i_pin (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .match_a_i(set_a),
    .match_b_i(set_b),
    .sel_a_i  (os_q[1:0]),
    .sel_b_i  (os_q[3:2]),
    .pin_o    (tmo_o)
  );

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: rdata_o = {5'b0, clk_sel_q};
      ADDR_STAT: rdata_o = {flag_b_q, flag_a_q, flag_o_q, 1'b1, os_q};
      ADDR_CNT:  rdata_o = cnt_q;
      ADDR_TCA:  rdata_o = tca_q;
      ADDR_TCB:  rdata_o = tcb_q;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cmt_timer_chk.sv
module cmt_timer_chk
  import cmt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [2:0]        clk_sel_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] tca_q,
  input logic              flag_a_q,
  input logic              flag_o_q
);
  assert_stopped_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clk_sel_q == 3'b000 || clk_sel_q == 3'b100) && !(wr_i && addr_i == ADDR_CNT))
      |=> $stable(cnt_q));

  assert_match_a_value_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_a_q) |-> (cnt_q == $past(tca_q)));

  assert_overflow_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o_q) |-> ($past(cnt_q) == 8'hFF && cnt_q == 8'h00));

  assert_unused_bit_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_STAT) |-> rdata_o[4]);

  assert_clear_by_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_a_q) |-> $past(wr_i && addr_i == ADDR_STAT && !wdata_i[6]));

  assert_const_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_TCA) |=> (tca_q == $past(wdata_i)));
endmodule

bind cmt_timer cmt_timer_chk i_chk (.*);

// File: tb/test_cmt_timer.sv
module test_cmt_timer;
  import cmt_pkg::*;

  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr_i = '0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       ext_clk_i = 1'b0;
  logic       tmo_o;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cmt_timer i_cmt_timer (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // all bus tasks start just after a falling edge and end on the next one
  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic ext_pulse();
    ext_clk_i = 1'b1;
    repeat (4) @(negedge clk_i);
    ext_clk_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic expect_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    peek(a, v);
    chk(req, v, exp);
  endtask

  task automatic flush_flags();
    logic [7:0] v;
    bus_read(ADDR_STAT, v);
    bus_write(ADDR_STAT, 8'h00);
  endtask

  task automatic t_reset();
    expect_reg("R1 ctrl", ADDR_CTRL, 8'h00);
    expect_reg("R1 stat", ADDR_STAT, 8'h10);
    expect_reg("R1 cnt",  ADDR_CNT,  8'h00);
    expect_reg("R1 tca",  ADDR_TCA,  8'hFF);
    expect_reg("R1 tcb",  ADDR_TCB,  8'hFF);
    chk("R1 tmo", {7'b0, tmo_o}, 8'h00);
  endtask

  task automatic t_regs();
    bus_write(ADDR_TCA, 8'h5A);
    bus_write(ADDR_TCB, 8'hA5);
    bus_write(ADDR_CNT, 8'h33);
    bus_write(ADDR_CTRL, 8'hFC);
    expect_reg("R11 tca",  ADDR_TCA,  8'h5A);
    expect_reg("R11 tcb",  ADDR_TCB,  8'hA5);
    expect_reg("R11 cnt",  ADDR_CNT,  8'h33);
    expect_reg("R11 ctrl", ADDR_CTRL, 8'h04);
  endtask

  task automatic t_stop();
    bus_write(ADDR_CTRL, 8'h00);
    repeat (40) @(negedge clk_i);
    ext_pulse();
    expect_reg("R2 sel000", ADDR_CNT, 8'h33);
    bus_write(ADDR_CTRL, 8'h04);
    repeat (1100) @(negedge clk_i);
    ext_pulse();
    ext_pulse();
    expect_reg("R2 sel100", ADDR_CNT, 8'h33);
  endtask

  task automatic t_prescale(input logic [2:0] sel, input int div);
    logic [7:0] c0, c1;
    bus_write(ADDR_CNT, 8'h00);
    bus_write(ADDR_CTRL, {5'b0, sel});
    peek(ADDR_CNT, c0);
    repeat (4 * div) @(negedge clk_i);
    peek(ADDR_CNT, c1);
    chk($sformatf("R3 div%0d", div), c1 - c0, 8'd4);
    bus_write(ADDR_CTRL, 8'h00);
  endtask

  task automatic t_ext(input logic [2:0] sel, input logic [7:0] exp);
    bus_write(ADDR_CTRL, {5'b0, sel});
    bus_write(ADDR_CNT, 8'h00);
    repeat (3) ext_pulse();
    expect_reg($sformatf("R4 sel%0b", sel), ADDR_CNT, exp);
  endtask

  task automatic t_match();
    bus_write(ADDR_CTRL, 8'h05);
    bus_write(ADDR_TCA, 8'h10);
    bus_write(ADDR_TCB, 8'h12);
    bus_write(ADDR_CNT, 8'h0F);
    ext_pulse();
    expect_reg("R5 flag A", ADDR_STAT, 8'h50);
    ext_pulse();
    ext_pulse();
    expect_reg("R5 flag B", ADDR_STAT, 8'hD0);
  endtask

  task automatic t_clear();
    logic [7:0] v;
    bus_write(ADDR_STAT, 8'h00);
    expect_reg("R8 no read", ADDR_STAT, 8'hD0);
    bus_write(ADDR_STAT, 8'hFF);
    expect_reg("R7 write ones", ADDR_STAT, 8'hDF);
    bus_write(ADDR_STAT, 8'h00);
    bus_read(ADDR_STAT, v);
    chk("R8 read value", v, 8'hD0);
    bus_write(ADDR_STAT, 8'h40);
    expect_reg("R8 clear B only", ADDR_STAT, 8'h50);
    bus_write(ADDR_STAT, 8'h00);
    expect_reg("R8 permit ends", ADDR_STAT, 8'h50);
    flush_flags();
    expect_reg("R8 cleared", ADDR_STAT, 8'h10);
    bus_read(ADDR_STAT, v);
    bus_write(ADDR_CNT, 8'h0F);
    ext_pulse();
    bus_write(ADDR_STAT, 8'h00);
    expect_reg("R8 stale read", ADDR_STAT, 8'h50);
    flush_flags();
  endtask

  task automatic t_overflow();
    bus_write(ADDR_TCA, 8'h40);
    bus_write(ADDR_TCB, 8'h41);
    bus_write(ADDR_CNT, 8'hFE);
    ext_pulse();
    expect_reg("R6 at FF", ADDR_STAT, 8'h10);
    ext_pulse();
    expect_reg("R6 wrap cnt", ADDR_CNT, 8'h00);
    expect_reg("R6 wrap flag", ADDR_STAT, 8'h30);
    flush_flags();
  endtask

  task automatic t_set_wins();
    logic [7:0] v;
    bus_write(ADDR_TCA, 8'h20);
    bus_write(ADDR_CNT, 8'h1F);
    ext_pulse();
    bus_write(ADDR_CNT, 8'h1F);
    bus_read(ADDR_STAT, v);
    chk("R9 armed value", v, 8'h50);
    ext_clk_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    bus_write(ADDR_STAT, 8'h00);  // lands on the counting edge
    ext_clk_i = 1'b0;
    repeat (4) @(negedge clk_i);
    expect_reg("R9 cnt", ADDR_CNT, 8'h20);
    expect_reg("R9 flag kept", ADDR_STAT, 8'h50);
    flush_flags();
  endtask

  task automatic t_pin();
    bus_write(ADDR_TCA, 8'h05);
    bus_write(ADDR_TCB, 8'h07);
    bus_write(ADDR_STAT, 8'h06);
    bus_write(ADDR_CNT, 8'h04);
    ext_pulse();
    chk("R10 A high", {7'b0, tmo_o}, 8'h01);
    ext_pulse();
    ext_pulse();
    chk("R10 B low", {7'b0, tmo_o}, 8'h00);
    bus_write(ADDR_STAT, 8'h03);
    bus_write(ADDR_CNT, 8'h04);
    ext_pulse();
    chk("R10 A toggle 1", {7'b0, tmo_o}, 8'h01);
    bus_write(ADDR_CNT, 8'h04);
    ext_pulse();
    chk("R10 A toggle 0", {7'b0, tmo_o}, 8'h00);
    ext_pulse();
    ext_pulse();
    chk("R10 B keep", {7'b0, tmo_o}, 8'h00);
    bus_write(ADDR_TCA, 8'h09);
    bus_write(ADDR_TCB, 8'h09);
    bus_write(ADDR_STAT, 8'h09);
    bus_write(ADDR_CNT, 8'h08);
    ext_pulse();
    chk("R10 B priority", {7'b0, tmo_o}, 8'h01);
    bus_write(ADDR_STAT, 8'h00);
    bus_write(ADDR_CNT, 8'h08);
    ext_pulse();
    chk("R10 both keep", {7'b0, tmo_o}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_regs();
    t_stop();
    t_prescale(3'b001, 8);
    t_prescale(3'b010, 64);
    t_prescale(3'b011, 1024);
    t_ext(3'b101, 8'd3);
    t_ext(3'b110, 8'd3);
    t_ext(3'b111, 8'd6);
    t_match();
    t_clear();
    t_overflow();
    t_set_wins();
    t_pin();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule